// File: doc/BRIEF.md
# Four-Lane Register Rename Stage

This block renames a group of up to four instructions in one clock cycle. It translates their architectural register names into names from a larger physical register file. That file holds both committed values and values still in flight. A map table gives the current physical register for each architectural register. A free bitmap tracks which physical registers can be handed out.

Each lane that writes a destination receives a fresh physical register. It also receives the physical register that the destination named before, so that register can be released once the instruction commits. Sources and old destinations see the mappings created by earlier lanes of the same group. One architectural register may be renamed several times in a single group. A group is renamed whole or not at all. When too few physical registers are free, the group stalls and the front end holds it. A commit port of four lanes returns physical registers to the free bitmap.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers 32 to 63 are free, and the others are not.
- R2: A lane's source whose architectural register is not written by any earlier lane of the group reads the map table entry.
- R3: A lane's source that names the destination of one or more earlier lanes in the same group reads the new physical register of the youngest such lane.
- R4: Each renaming lane reports on `pd_old` the mapping its destination had before the lane. That mapping is the new register of the youngest earlier lane in the group that wrote the same destination, if there is one.
- R5: When several lanes of an accepted group write one architectural register, the map table keeps the youngest lane's mapping.
- R6: The new registers of an accepted group are the lowest-numbered free registers, handed out in lane order with lane 0 taking the lowest. No two lanes get the same register.
- R7: A lane with `dst_en` low or destination 0 takes no register and reports 0 on `pd_new` and `pd_old`. A source naming register 0 reads physical register 0.
- R8: When `grp_valid` is high but the group needs more registers than are free, `rn_ok` is low and neither the map table nor the free bitmap changes.
- R9: A physical register released on the commit port is free from the next cycle, not in the same cycle. A release of physical register 0 is ignored.
- R10: While `grp_valid` is low, `rn_ok` is low and no mapping or allocation changes.

Lane k uses bits [k*5 +: 5] of the architectural fields and bits [k*6 +: 6] of the physical fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A group is offered this cycle |
| dst_en | input | 4 | Per-lane flag: the lane writes a destination |
| dst_ar | input | 20 | Per-lane architectural destination |
| src1_ar | input | 20 | Per-lane first architectural source |
| src2_ar | input | 20 | Per-lane second architectural source |
| rel_valid | input | 4 | Per-lane commit release strobe |
| rel_pr | input | 24 | Per-lane physical register to release |
| rn_ok | output | 1 | The group is renamed this cycle |
| ps1 | output | 24 | Per-lane first physical source |
| ps2 | output | 24 | Per-lane second physical source |
| pd_new | output | 24 | Per-lane newly allocated physical destination |
| pd_old | output | 24 | Per-lane previous physical destination |

## Verification
All rename outputs and `rn_ok` are combinational in the offered group and the current state. The bench therefore drives each group on a falling edge and compares one nanosecond later, in the same cycle. The map table and free bitmap take effect at the next rising edge, so their results show up only in the group offered after it. A release seen at an edge may be used by the group offered in the cycle after. The bench keeps its own in-order model of map and free set, which it updates after each rising edge, so every expected value refers to the state that edge produced.

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int LANES = 4,
  parameter int AREGS = 32,
  parameter int PREGS = 64,
  localparam int AW = $clog2(AREGS),
  localparam int PW = $clog2(PREGS),
  localparam int CW = PW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grp_valid,
  input  logic [LANES-1:0]   dst_en,
  input  logic [LANES*AW-1:0] dst_ar,
  input  logic [LANES*AW-1:0] src1_ar,
  input  logic [LANES*AW-1:0] src2_ar,
  input  logic [LANES-1:0]   rel_valid,
  input  logic [LANES*PW-1:0] rel_pr,
  output logic               rn_ok,
  output logic [LANES*PW-1:0] ps1,
  output logic [LANES*PW-1:0] ps2,
  output logic [LANES*PW-1:0] pd_new,
  output logic [LANES*PW-1:0] pd_old
);

  logic [PW-1:0]    map_q [AREGS];
  logic [PREGS-1:0] free_q;
  logic [LANES-1:0] need;
  logic [PW-1:0]    cand [LANES];
  logic [PREGS-1:0] take_mask, rel_mask;
  logic [CW-1:0]    free_cnt, need_cnt, rel_cnt;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      need[k] = dst_en[k] && (dst_ar[k*AW +: AW] != '0);
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < PREGS; i++) free_cnt = free_cnt + CW'(free_q[i]);
    need_cnt = '0;
    for (int k = 0; k < LANES; k++) need_cnt = need_cnt + CW'(need[k]);
  end

  assign rn_ok = grp_valid && (need_cnt <= free_cnt);

  always_comb begin
    logic [PREGS-1:0] avail;
    avail = free_q;
    take_mask = '0;
    for (int k = 0; k < LANES; k++) begin
      cand[k] = '0;
      for (int i = PREGS - 1; i >= 0; i--)
        if (avail[i]) cand[k] = PW'(i);
      if (need[k] && avail[cand[k]]) begin
        avail[cand[k]] = 1'b0;
        take_mask[cand[k]] = 1'b1;
      end
    end
  end

  always_comb begin
    rel_mask = '0;
    rel_cnt = '0;
    for (int k = 0; k < LANES; k++)
      if (rel_valid[k] && rel_pr[k*PW +: PW] != '0 && !rel_mask[rel_pr[k*PW +: PW]]) begin
        rel_mask[rel_pr[k*PW +: PW]] = 1'b1;
        rel_cnt = rel_cnt + 1'b1;
      end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [AW-1:0] a1, a2, ad;
      logic [PW-1:0] p1, p2, po;
      a1 = src1_ar[k*AW +: AW];
      a2 = src2_ar[k*AW +: AW];
      ad = dst_ar[k*AW +: AW];
      p1 = map_q[a1];
      p2 = map_q[a2];
      po = map_q[ad];
      for (int j = 0; j < LANES; j++)
        if (j < k && need[j]) begin
          if (dst_ar[j*AW +: AW] == a1) p1 = cand[j];
          if (dst_ar[j*AW +: AW] == a2) p2 = cand[j];
          if (dst_ar[j*AW +: AW] == ad) po = cand[j];
        end
      ps1[k*PW +: PW]    = p1;
      ps2[k*PW +: PW]    = p2;
      pd_new[k*PW +: PW] = need[k] ? cand[k] : '0;
      pd_old[k*PW +: PW] = need[k] ? po : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < AREGS; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < PREGS; i++) free_q[i] <= (i >= AREGS);
    end else begin
      if (rn_ok)
        for (int k = 0; k < LANES; k++)
          if (need[k]) map_q[dst_ar[k*AW +: AW]] <= cand[k];
      free_q <= (free_q & ~(rn_ok ? take_mask : '0)) | rel_mask;
    end
  end

  AST_ZERO_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    map_q[0] == '0); // R7

  AST_FREE_ACCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> free_cnt == $past(free_cnt - (rn_ok ? need_cnt : '0) + rel_cnt)); // R9

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rn_ok && rel_mask == '0) |=> $stable(free_q)); // R8

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    AST_TAKEN_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_ok && need[k] && !rel_mask[cand[k]]) |=> !free_q[$past(cand[k])]); // R6
    for (genvar j = 0; j < k; j++) begin : g_pair
      AST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_ok && need[j] && need[k]) |-> cand[j] != cand[k]); // R6
    end
  end

endmodule

// File: tb/tb_reg_rename.sv
`timescale 1ns/1ps
module tb_reg_rename;
  localparam int L = 4, AW = 5, PW = 6;

  logic clk = 0, rst_n = 0;
  logic grp_valid = 0;
  logic [L-1:0] dst_en = 0, rel_valid = 0;
  logic [L*AW-1:0] dst_ar = 0, src1_ar = 0, src2_ar = 0;
  logic [L*PW-1:0] rel_pr = 0;
  logic rn_ok;
  logic [L*PW-1:0] ps1, ps2, pd_new, pd_old;

  int n_run = 0, n_fail = 0;
  int m_map [32];
  bit m_free [64];
  int Z [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  reg_rename dut (.clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .dst_en(dst_en),
    .dst_ar(dst_ar), .src1_ar(src1_ar), .src2_ar(src2_ar), .rel_valid(rel_valid),
    .rel_pr(rel_pr), .rn_ok(rn_ok), .ps1(ps1), .ps2(ps2), .pd_new(pd_new), .pd_old(pd_old));

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic grp(input bit v, input int en[4], input int d[4], input int a[4], input int b[4],
                     input int cv[4], input int cp[4], input string tag);
    int tmap [32];
    bit tfree [64];
    int nneed, nfree, e1, e2, en_, eo, p;
    bit eok;
    tmap = m_map; tfree = m_free;
    @(negedge clk);
    grp_valid = v;
    for (int k = 0; k < L; k++) begin
      dst_en[k] = en[k][0];
      dst_ar[k*AW +: AW] = AW'(d[k]);
      src1_ar[k*AW +: AW] = AW'(a[k]);
      src2_ar[k*AW +: AW] = AW'(b[k]);
      rel_valid[k] = cv[k][0];
      rel_pr[k*PW +: PW] = PW'(cp[k]);
    end
    #1;
    nneed = 0; nfree = 0;
    for (int k = 0; k < L; k++) if (en[k] != 0 && d[k] != 0) nneed++;
    for (int i = 0; i < 64; i++) if (m_free[i]) nfree++;
    eok = v && (nneed <= nfree);
    check(rn_ok == eok, tag, "rn_ok", int'(rn_ok), int'(eok));
    for (int k = 0; k < L; k++) begin
      e1 = tmap[a[k]]; e2 = tmap[b[k]]; en_ = 0; eo = 0;
      if (en[k] != 0 && d[k] != 0) begin
        p = -1;
        for (int i = 63; i >= 0; i--) if (tfree[i]) p = i;
        if (p >= 0) begin
          en_ = p; eo = tmap[d[k]]; tmap[d[k]] = p; tfree[p] = 0;
        end
      end
      check(int'(ps1[k*PW +: PW]) == e1, tag, $sformatf("lane%0d ps1", k), int'(ps1[k*PW +: PW]), e1);
      check(int'(ps2[k*PW +: PW]) == e2, tag, $sformatf("lane%0d ps2", k), int'(ps2[k*PW +: PW]), e2);
      if (eok) begin
        check(int'(pd_new[k*PW +: PW]) == en_, tag, $sformatf("lane%0d pd_new", k), int'(pd_new[k*PW +: PW]), en_);
        check(int'(pd_old[k*PW +: PW]) == eo, tag, $sformatf("lane%0d pd_old", k), int'(pd_old[k*PW +: PW]), eo);
      end
    end
    @(posedge clk);
    if (eok) begin m_map = tmap; m_free = tfree; end
    for (int k = 0; k < L; k++) if (cv[k] != 0 && cp[k] != 0) m_free[cp[k]] = 1;
    #0.5;
    grp_valid = 0; dst_en = 0; rel_valid = 0;
  endtask

  task automatic t_reset();
    for (int g = 0; g < 4; g++)
      grp(1, Z, Z, '{8*g, 8*g+2, 8*g+4, 8*g+6}, '{8*g+1, 8*g+3, 8*g+5, 8*g+7}, Z, Z, "R1");
  endtask

  task automatic t_bypass();
    grp(1, '{1, 0, 1, 0}, '{5, 0, 5, 0}, '{1, 5, 5, 5}, '{2, 7, 3, 3}, Z, Z, "R3");
    grp(1, Z, Z, '{5, 7, 3, 1}, '{6, 8, 4, 2}, Z, Z, "R2");
  endtask

  task automatic t_repeat();
    grp(1, '{1, 1, 1, 1}, '{9, 9, 9, 9}, '{9, 9, 9, 9}, '{10, 9, 11, 9}, Z, Z, "R4");
    grp(1, Z, Z, '{9, 9, 9, 9}, '{5, 10, 11, 9}, Z, Z, "R5");
  endtask

  task automatic t_zero();
    grp(1, '{1, 0, 1, 1}, '{0, 12, 0, 13}, '{0, 0, 12, 0}, '{13, 0, 0, 0}, Z, Z, "R7");
  endtask

  task automatic t_idle();
    grp(0, '{1, 1, 1, 1}, '{14, 15, 16, 17}, '{14, 15, 16, 17}, Z, Z, Z, "R10");
    grp(1, '{1, 0, 0, 0}, '{18, 0, 0, 0}, '{14, 15, 16, 17}, '{18, 0, 0, 0}, Z, Z, "R10");
  endtask

  task automatic t_exhaust();
    for (int g = 0; g < 8; g++)
      grp(1, '{1, 1, 1, 1}, '{20 + g, 21 + g, 22, 3}, '{20 + g, 22, 3, 21}, '{1, 2, 3, 4}, Z, Z, "R6");
    grp(1, '{1, 0, 0, 0}, '{25, 0, 0, 0}, '{25, 3, 22, 0}, Z, Z, Z, "R8");
    grp(1, Z, Z, '{25, 3, 22, 21}, '{20, 24, 23, 26}, Z, Z, "R8");
  endtask

  task automatic t_commit();
    grp(1, '{1, 0, 0, 0}, '{27, 0, 0, 0}, Z, Z, '{1, 1, 0, 0}, '{40, 33, 0, 0}, "R9");
    grp(1, '{1, 1, 0, 0}, '{27, 28, 0, 0}, '{27, 27, 0, 0}, '{28, 28, 0, 0}, Z, Z, "R9");
    grp(1, Z, Z, '{27, 28, 0, 0}, Z, '{1, 0, 0, 0}, '{0, 0, 0, 0}, "R9");
    grp(1, '{1, 0, 0, 0}, '{29, 0, 0, 0}, '{29, 0, 0, 0}, Z, Z, Z, "R9");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_map[i] = i;
    for (int i = 0; i < 64; i++) m_free[i] = (i >= 32);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_bypass();
    t_repeat();
    t_zero();
    t_idle();
    t_exhaust();
    t_commit();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule